// File: doc/BRIEF.md
# SDH Multiframe V1 Strobe Generator

This block sits on an STM-1 receive telecom bus, one byte per clock, and produces the timing strobes that a downstream tributary pointer processor expects. The input bus carries an 8-bit data byte with three qualifiers. The first is a single-pulse indicator shared by J0 and J1. The second is a payload enable. The third is an enable that flags the H4 byte. The block first registers all inputs. It then re-issues the data together with a C1/J1 marker, a payload flag and a tributary multiframe strobe. The strobe lands on the V1 byte, which is the third bus slot after J1, and only in the frame that opens the four-frame tributary multiframe. All four outputs leave through one shared output register. That register is clocked by the inverted bus clock, so data and strobes stay aligned with each other.

The frame's position inside the multiframe is held in a two-bit phase count. The count steps at each J0. The H4 byte can force it back into line with the multiframe. A separate retiming clock domain runs a free-running 2 kHz square wave. One period of this wave spans four frames, each of FRAME_SLOTS clock cycles of the retiming clock. The inverted bus clock comes in as a port. The block does not derive it.

Top module: `mfv1_strobe_gen`

## Requirements
- R1: While reset is high, and after it, all outputs are 0 at the following inverted-clock edge. No multiframe strobe is issued until a J0 has been seen after reset, even if J1 pulses and phase zero occur.
- R2: A byte presented on `bus_data` is captured on the rising edge of `clk`. It appears on `out_data` at the next rising edge of `clk_n` and holds for one full cycle.
- R3: `out_c1j1` and `out_pl` copy `bus_j0j1` and `bus_pay` with exactly the R2 latency. Both J0 and J1 pulses are passed on.
- R4: A `bus_j0j1` pulse with `bus_pay` low is a J0 (frame start), wherever it falls. A pulse with `bus_pay` high is a J1.
- R5: `out_mf` is high for exactly the output cycle of the byte that follows a J1 by 3 slots (V1), and only in a multiframe-start frame. It is low in every other cycle.
- R6: The phase count steps by one at every J0 and wraps modulo 4. A frame is a multiframe-start frame when the count is 0 after its J0.
- R7: When `bus_h4` is high and `bus_data[1:0]` is 2'b00, the following frame becomes a multiframe-start frame. Any other H4 value, or `bus_data[1:0]` of 00 without `bus_h4`, leaves the count untouched.
- R8: `mf_ref` is a square wave with a period of 4*FRAME_SLOTS `rtm_clk` cycles. It is high for the first 2*FRAME_SLOTS cycles of each period, starting from the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus byte clock |
| clk_n | input | 1 | Inverted bus clock; clocks the output register |
| rst | input | 1 | Synchronous active-high reset, all domains |
| rtm_clk | input | 1 | Retiming-domain clock |
| bus_data | input | 8 | Incoming telecom bus byte |
| bus_j0j1 | input | 1 | Shared J0/J1 single pulse |
| bus_pay | input | 1 | Payload enable |
| bus_h4 | input | 1 | H4 byte enable |
| out_data | output | 8 | Realigned data byte |
| out_c1j1 | output | 1 | C1/J1 marker toward the pointer processor |
| out_pl | output | 1 | Payload indicator |
| out_mf | output | 1 | Tributary multiframe strobe on V1 |
| mf_ref | output | 1 | 2 kHz multiframe reference, retiming domain |

## Verification
The first test sends a frame that has J1 but no J0 at phase zero, which separates gating on seen-J0 from gating on the phase alone. A ten-frame sequence follows. Its H4 codes let the count run free through a full wrap, then resynchronise it once from phase 1 and once early from phase 2, which separates "count wraps" from "H4 forces". One frame carries an extra mid-frame J0 with payload low, which shows that J0 is told from J1 by the payload enable and not by position. The retiming wave is timed by its high width and its low width, and a mid-run reset confirms that all outputs clear.

// File: rtl/mfv1_pkg.sv
package mfv1_pkg;

    localparam int DATA_W = 8;
    localparam int PH_W   = 2;
    localparam int MF_FRAMES = 1 << PH_W;

    typedef logic [PH_W-1:0] phase_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              j0j1;
        logic              pay;
        logic              h4;
    } bus_t;

    typedef struct packed {
        logic j0;
        logic j1;
        logic h4_start;
    } evt_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              c1j1;
        logic              pl;
        logic              mf;
    } out_t;

    function automatic logic is_start_code(logic [PH_W-1:0] code);
        return code == '0;
    endfunction

endpackage

// File: rtl/mfv1_capture.sv
module mfv1_capture
    import mfv1_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  bus_t bus_in,
    output bus_t bus_q,
    output evt_t evt
);

    always_ff @(posedge clk) begin
        if (rst) bus_q <= '0;
        else     bus_q <= bus_in;
    end

    // pulse meaning is set by the payload enable, not by position
    assign evt.j0       = bus_q.j0j1 & ~bus_q.pay;
    assign evt.j1       = bus_q.j0j1 &  bus_q.pay;
    assign evt.h4_start = bus_q.h4 & is_start_code(bus_q.data[PH_W-1:0]);

endmodule

// File: rtl/mfv1_v1_detect.sv
module mfv1_v1_detect
    import mfv1_pkg::*;
#(
    parameter int V1_OFFSET = 3
) (
    input  logic clk,
    input  logic rst,
    input  evt_t evt,
    output logic mf_now
);

    localparam int CW  = $clog2(V1_OFFSET + 2);
    localparam int SAT = V1_OFFSET + 1;

    phase_t               phase;
    logic                 seen_j0;
    logic [V1_OFFSET-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= '0;
            seen_j0 <= 1'b0;
        end else begin
            if (evt.h4_start)  phase <= '1;
            else if (evt.j0)   phase <= phase + phase_t'(1);
            if (evt.j0)        seen_j0 <= 1'b1;
        end
    end

    for (genvar i = 0; i < V1_OFFSET; i++) begin : g_tap
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= evt.j1;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign mf_now = chain[V1_OFFSET-1] & seen_j0 & (phase == '0);

    // checker: distance since the last J1, saturating
    logic [CW-1:0] since_j1;
    always_ff @(posedge clk) begin
        if (rst)                          since_j1 <= CW'(SAT);
        else if (evt.j1)                  since_j1 <= CW'(1);
        else if (since_j1 != CW'(SAT))    since_j1 <= since_j1 + CW'(1);
    end

    assert_v1_offset_R5: assert property (@(posedge clk) disable iff (rst)
        mf_now |-> since_j1 == CW'(V1_OFFSET));

    assert_phase_step_R6: assert property (@(posedge clk) disable iff (rst)
        (evt.j0 && !evt.h4_start) |=> phase == $past(phase) + phase_t'(1));

    assert_h4_resync_R7: assert property (@(posedge clk) disable iff (rst)
        evt.h4_start |=> phase == '1);

endmodule

// File: rtl/mfv1_realign.sv
module mfv1_realign
    import mfv1_pkg::*;
(
    input  logic              clk_n,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_in,
    input  logic              c1j1_in,
    input  logic              pl_in,
    input  logic              mf_in,
    output out_t              out_q
);

    always_ff @(posedge clk_n) begin
        if (rst) out_q <= '0;
        else     out_q <= '{data: data_in, c1j1: c1j1_in, pl: pl_in, mf: mf_in};
    end

endmodule

// File: rtl/mfv1_mf_ref.sv
module mfv1_mf_ref
    import mfv1_pkg::*;
#(
    parameter int FRAME_SLOTS = 2430
) (
    input  logic rtm_clk,
    input  logic rst,
    output logic ref_q
);

    localparam int SLOT_W = $clog2(FRAME_SLOTS);
    localparam int HALF   = MF_FRAMES / 2;

    logic [SLOT_W-1:0] slot_cnt;
    phase_t            frm_cnt;

    always_ff @(posedge rtm_clk) begin
        if (rst) begin
            slot_cnt <= '0;
            frm_cnt  <= '0;
            ref_q    <= 1'b0;
        end else begin
            ref_q <= (int'(frm_cnt) < HALF);
            if (slot_cnt == SLOT_W'(FRAME_SLOTS - 1)) begin
                slot_cnt <= '0;
                frm_cnt  <= frm_cnt + phase_t'(1);
            end else begin
                slot_cnt <= slot_cnt + SLOT_W'(1);
            end
        end
    end

    assert_ref_edge_R8: assert property (@(posedge rtm_clk) disable iff (rst)
        $rose(ref_q) |-> (slot_cnt == SLOT_W'(1) && frm_cnt == '0));

endmodule

// File: rtl/mfv1_strobe_gen.sv
module mfv1_strobe_gen
    import mfv1_pkg::*;
#(
    parameter int FRAME_SLOTS = 2430,
    parameter int V1_OFFSET   = 3
) (
    input  logic              clk,
    input  logic              clk_n,
    input  logic              rst,
    input  logic              rtm_clk,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_j0j1,
    input  logic              bus_pay,
    input  logic              bus_h4,
    output logic [DATA_W-1:0] out_data,
    output logic              out_c1j1,
    output logic              out_pl,
    output logic              out_mf,
    output logic              mf_ref
);

    bus_t bus_in, bus_q;
    evt_t evt;
    logic mf_now;
    out_t out_q;

    assign bus_in = '{data: bus_data, j0j1: bus_j0j1, pay: bus_pay, h4: bus_h4};

    mfv1_capture u_capture (
        .clk   (clk),
        .rst   (rst),
        .bus_in(bus_in),
        .bus_q (bus_q),
        .evt   (evt)
    );

    mfv1_v1_detect #(.V1_OFFSET(V1_OFFSET)) u_detect (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .mf_now(mf_now)
    );

    mfv1_realign u_realign (
        .clk_n  (clk_n),
        .rst    (rst),
        .data_in(bus_q.data),
        .c1j1_in(bus_q.j0j1),
        .pl_in  (bus_q.pay),
        .mf_in  (mf_now),
        .out_q  (out_q)
    );

    mfv1_mf_ref #(.FRAME_SLOTS(FRAME_SLOTS)) u_mf_ref (
        .rtm_clk(rtm_clk),
        .rst    (rst),
        .ref_q  (mf_ref)
    );

    assign out_data = out_q.data;
    assign out_c1j1 = out_q.c1j1;
    assign out_pl   = out_q.pl;
    assign out_mf   = out_q.mf;

endmodule

// File: tb/mfv1_strobe_gen_tb.sv
module mfv1_strobe_gen_tb;

    localparam int FL        = 24;
    localparam int PAY_START = 3;
    localparam int J1_SLOT   = 5;
    localparam int V1_SLOT   = J1_SLOT + 3;
    localparam int H4_SLOT   = 15;
    localparam int FRAME_SLOTS = 2430;
    localparam int NVEC      = 10;

    // each entry: {H4 low bits sent in this frame, strobe expected in this frame}
    localparam logic [2:0] VEC [0:NVEC-1] = '{
        {2'b01, 1'b0}, {2'b10, 1'b0}, {2'b11, 1'b0}, {2'b01, 1'b1},
        {2'b00, 1'b0}, {2'b01, 1'b1}, {2'b10, 1'b0}, {2'b00, 1'b0},
        {2'b11, 1'b1}, {2'b10, 1'b0}
    };

    logic clk = 1'b0, rtm_clk = 1'b0, rst = 1'b1;
    logic clk_n;
    logic [7:0] bus_data = '0;
    logic bus_j0j1 = 1'b0, bus_pay = 1'b0, bus_h4 = 1'b0;
    logic [7:0] out_data;
    logic out_c1j1, out_pl, out_mf, mf_ref;

    int checks = 0;
    int fails  = 0;
    int frame_no = 0;

    always #5 clk = ~clk;
    always #4 rtm_clk = ~rtm_clk;
    assign clk_n = ~clk;

    mfv1_strobe_gen #(.FRAME_SLOTS(FRAME_SLOTS), .V1_OFFSET(3)) u_dut (
        .clk(clk), .clk_n(clk_n), .rst(rst), .rtm_clk(rtm_clk),
        .bus_data(bus_data), .bus_j0j1(bus_j0j1), .bus_pay(bus_pay), .bus_h4(bus_h4),
        .out_data(out_data), .out_c1j1(out_c1j1), .out_pl(out_pl), .out_mf(out_mf),
        .mf_ref(mf_ref)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // One frame; inputs driven 7 ns after a rising edge, outputs sampled 7 ns after the capturing edge
    task automatic run_frame(input logic [1:0] code, input bit exp_mf,
                             input bit with_j0, input int extra_j0);
        frame_no++;
        for (int s = 0; s < FL; s++) begin
            logic [7:0] d;
            logic jp, pp, hp, mfe;
            d  = (s == H4_SLOT) ? {6'b101100, code} : 8'((s * 7 + frame_no * 13) | 1);
            jp = (s == 0 && with_j0) || (s == J1_SLOT) || (extra_j0 > 0 && s == extra_j0);
            pp = (s >= PAY_START);
            hp = (s == H4_SLOT);
            mfe = exp_mf && (s == V1_SLOT);
            bus_data = d; bus_j0j1 = jp; bus_pay = pp; bus_h4 = hp;
            @(posedge clk);
            #7;
            chk(out_data == d, "R2", "out_data", out_data, d);
            chk(out_c1j1 == jp && out_pl == pp, "R3", "c1j1/pl",
                {out_c1j1, out_pl}, {jp, pp});
            chk(out_mf == mfe, "R5", $sformatf("out_mf frame %0d slot %0d", frame_no, s),
                out_mf, mfe);
        end
    endtask

    initial begin
        #1_500_000;
        $display("FAIL watchdog expired");
        fails++;
        checks++;
        finish_run();
    end

    initial begin
        // reset state (R1)
        repeat (5) @(posedge clk);
        #7;
        chk(out_data == 0 && out_c1j1 == 0 && out_pl == 0 && out_mf == 0, "R1",
            "outputs in reset", {out_data, out_c1j1, out_pl, out_mf}, 0);
        chk(mf_ref == 0, "R8", "mf_ref in reset", mf_ref, 0);
        rst = 1'b0;

        // R1: J1 without any prior J0 while phase is zero: no strobe
        run_frame(2'b01, 1'b0, 1'b0, 0);

        // R6/R7: table of frames
        for (int v = 0; v < NVEC; v++) begin
            run_frame(VEC[v][2:1], VEC[v][0], 1'b1, 0);
        end

        // R4: after table phase is 1; next J0 -> 2, extra J0 at slot 2 (payload low) -> 3
        run_frame(2'b01, 1'b0, 1'b1, 2);
        // R4/R6: so the following frame is phase 0 and strobes
        run_frame(2'b10, 1'b1, 1'b1, 0);
        // R7: code 10 did not resync; next is phase 1
        run_frame(2'b11, 1'b0, 1'b1, 0);

        // R8: mf_ref high and low widths in rtm cycles
        begin
            int hi = 0, lo = 0;
            @(negedge rtm_clk);
            while (mf_ref) @(negedge rtm_clk);
            while (!mf_ref) @(negedge rtm_clk);
            while (mf_ref) begin hi++; @(negedge rtm_clk); end
            while (!mf_ref) begin lo++; @(negedge rtm_clk); end
            chk(hi == 2 * FRAME_SLOTS, "R8", "mf_ref high width", hi, 2 * FRAME_SLOTS);
            chk(lo == 2 * FRAME_SLOTS, "R8", "mf_ref low width", lo, 2 * FRAME_SLOTS);
        end

        // R1: reset mid-run clears outputs, data no longer passes
        @(posedge clk); #7;
        bus_data = 8'hA5; bus_j0j1 = 1'b1; bus_pay = 1'b1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #7;
        chk(out_data == 0 && out_c1j1 == 0 && out_pl == 0 && out_mf == 0, "R1",
            "outputs after mid-run reset", {out_data, out_c1j1, out_pl, out_mf}, 0);
        bus_data = '0; bus_j0j1 = 1'b0; bus_pay = 1'b0;
        rst = 1'b0;
        @(posedge clk); #7;

        // R1: after reset no strobe until a J0, even across several J1s at phase zero
        run_frame(2'b10, 1'b0, 1'b0, 0);
        run_frame(2'b10, 1'b0, 1'b0, 0);

        finish_run();
    end

endmodule